// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarms

This peripheral keeps time as a running count of seconds. A 32-bit up-counter and a companion down-counter move together on each pulse of a one-second tick input. When software loads them consistently, the two counters always add up to all ones. Two match registers are compared with the up-counter. When the count reaches a match value, a sticky status bit is set. Each status bit can be routed to a single interrupt output through its own enable bit.

Software reaches the block through a simple 32-bit register port. The port has a write strobe, a byte address and write data. Read data is combinational on the address. A control register can stop the counters so that they can be loaded, and it can force the counters back to zero. A scratch key register lets software record that the block has been set up. The key register is cleared only by the power-on reset, so it keeps its value across a core reset. Every other register returns to its reset value on a core reset.

Top module: `sec_rtc`

## Requirements
- R1: After a core reset the registers hold these values: up-counter 0, down-counter 0xFFFFFFFF, both match registers 0xFFFFFFFF, control 0, status 0. The interrupt output is low.
- R2: A tick pulse is a `tick_i` high for one clock while control bit 6 and control bit 4 are both clear. On such a pulse the up-counter increments by one and the down-counter decrements by one. A counter pair that starts with a sum of 0xFFFFFFFF keeps that sum.
- R3: While control bit 6 (halt) is set, ticks change neither counter.
- R4: A write to offset 0x00 (up-counter) or offset 0x04 (down-counter) loads that counter at the next clock, but only while halt is set and control bit 4 is clear. At any other time the write is ignored.
- R5: While control bit 4 (counter clear) is set, the up-counter is held at 0 and the down-counter at 0xFFFFFFFF. Ticks and counter writes are ignored during this time.
- R6: Status bit i (offset 0x14) is for match register i (offset 0x08 for i=0, offset 0x0C for i=1). The bit is set on a tick after which the up-counter equals match register i. A counter load that makes the two equal does not set it.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R8: While the counters are halted on a value equal to a match register, every tick sets that status bit again. Moving the match register to another value stops this.
- R9: `irq_o` is high exactly when (status bit0 and control bit0) or (status bit1 and control bit1).
- R10: The key register at offset 0x18 is a 32-bit read/write register. It keeps its value, for example 0xB5C13F27, through a core reset, and only the power-on reset clears it to 0.
- R11: Control reads back only bits 0-4, 6 and 7, and status bit 2 reads 0. Reads from unmapped offsets (for example 0x1C, 0x80, 0xFC) return 0, and writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low core reset, asynchronous |
| pwr_rst_n | input | 1 | Active-low power-on reset, clears the key register |
| tick_i | input | 1 | One-clock pulse each second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Match interrupt request |

## Verification
A register write or a tick takes effect at the clock edge on which it is presented. The new counter, status and register values can be read back right after that edge. `irq_o` is combinational from status and control, so it changes at that same edge. The bench applies each write or tick at a falling edge and removes it at the next falling edge, which leaves exactly one rising edge in between. It then reads combinationally one time step after that second falling edge, so every result is sampled one edge after its stimulus. The match sweeps cover every tick offset from 0 to 11 for both match registers. For each tick offset the expected status and interrupt state are computed from simple arithmetic.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    // number of match registers; their enables and status bits sit at bits 0..NUM_MATCH-1
    localparam int NUM_MATCH = 2;

    // byte offsets
    localparam int OFS_UP    = 'h00;
    localparam int OFS_DN    = 'h04;
    localparam int OFS_MATCH = 'h08;
    localparam int OFS_CTL   = 'h10;
    localparam int OFS_ST    = 'h14;
    localparam int OFS_KEY   = 'h18;

    // control layout
    localparam int CTL_W     = 8;
    localparam int CTL_SWRST = 4;
    localparam int CTL_HALT  = 6;
    localparam logic [CTL_W-1:0] CTL_KEEP = 8'hDF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_UP,
        SEL_DN,
        SEL_MATCH,
        SEL_CTL,
        SEL_ST,
        SEL_KEY
    } reg_sel_e;

endpackage

// File: rtl/sec_rtc_count.sv
module sec_rtc_count #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          halt,
    input  logic          swrst,
    input  logic          ld_up,
    input  logic          ld_dn,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] up_q,
    output logic [DW-1:0] dn_q,
    output logic [DW-1:0] up_nx
);

    typedef struct packed {
        logic [DW-1:0] up;
        logic [DW-1:0] dn;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (swrst) begin
            c_d.up = '0;
            c_d.dn = '1;
        end else if (halt) begin
            if (ld_up) c_d.up = ld_val;
            if (ld_dn) c_d.dn = ld_val;
        end else if (tick) begin
            c_d.up = c_q.up + DW'(1);
            c_d.dn = c_q.dn - DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.up <= '0;
            c_q.dn <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign up_q  = c_q.up;
    assign dn_q  = c_q.dn;
    assign up_nx = c_d.up;

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halt && !swrst) |=>
            (up_q == $past(up_q) + DW'(1)) && (dn_q == $past(dn_q) - DW'(1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !swrst && !ld_up && !ld_dn) |=> $stable(up_q) && $stable(dn_q));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_up && halt && !swrst) |=> (up_q == $past(ld_val)));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (up_q == '0) && (dn_q == '1));

endmodule

// File: rtl/sec_rtc_match.sv
module sec_rtc_match #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] up_nx,
    input  logic [DW-1:0] match_val,
    input  logic          clr,
    output logic          st_q
);

    logic st_d;
    logic hit;

    always_comb begin
        hit  = tick && (up_nx == match_val);
        st_d = hit || (st_q && !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= 1'b0;
        else        st_q <= st_d;
    end

    p_set_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q) |-> $past(tick));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (up_nx == match_val)) |=> st_q);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !tick) |=> !st_q);

endmodule

// File: rtl/sec_rtc_regs.sv
module sec_rtc_regs
    import sec_rtc_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pwr_rst_n,
    input  logic                             bus_we,
    input  logic [AW-1:0]                    bus_addr,
    input  logic [DW-1:0]                    bus_wdata,
    input  logic [DW-1:0]                    up_cnt,
    input  logic [DW-1:0]                    dn_cnt,
    input  logic [NUM_MATCH-1:0]             status,
    output logic [DW-1:0]                    bus_rdata,
    output logic [NUM_MATCH-1:0]             ctl_en,
    output logic                             ctl_halt,
    output logic                             ctl_swrst,
    output logic [NUM_MATCH-1:0][DW-1:0]     match_val,
    output logic                             ld_up,
    output logic                             ld_dn,
    output logic [NUM_MATCH-1:0]             clr_mask
);

    localparam int MIW = (NUM_MATCH > 1) ? $clog2(NUM_MATCH) : 1;

    typedef struct packed {
        logic [CTL_W-1:0]                ctl;
        logic [NUM_MATCH-1:0][DW-1:0]    match;
    } regs_t;

    regs_t         r_d, r_q;
    logic [DW-1:0] key_d, key_q;
    reg_sel_e      sel;
    logic [MIW-1:0] midx;

    // address decode
    always_comb begin
        sel  = SEL_NONE;
        midx = '0;
        if      (bus_addr == AW'(OFS_UP))  sel = SEL_UP;
        else if (bus_addr == AW'(OFS_DN))  sel = SEL_DN;
        else if (bus_addr == AW'(OFS_CTL)) sel = SEL_CTL;
        else if (bus_addr == AW'(OFS_ST))  sel = SEL_ST;
        else if (bus_addr == AW'(OFS_KEY)) sel = SEL_KEY;
        for (int i = 0; i < NUM_MATCH; i++) begin
            if (bus_addr == AW'(OFS_MATCH + 4 * i)) begin
                sel  = SEL_MATCH;
                midx = MIW'(i);
            end
        end
    end

    // next state of the software registers
    always_comb begin
        r_d   = r_q;
        key_d = key_q;
        if (bus_we) begin
            case (sel)
                SEL_CTL:   r_d.ctl = bus_wdata[CTL_W-1:0] & CTL_KEEP;
                SEL_MATCH: r_d.match[midx] = bus_wdata;
                SEL_KEY:   key_d = bus_wdata;
                default:   ;
            endcase
        end
    end

    // strobes toward the counters and status bits
    always_comb begin
        ld_up    = bus_we && (sel == SEL_UP);
        ld_dn    = bus_we && (sel == SEL_DN);
        clr_mask = (bus_we && (sel == SEL_ST)) ? bus_wdata[NUM_MATCH-1:0] : '0;
    end

    // read mux
    always_comb begin
        case (sel)
            SEL_UP:    bus_rdata = up_cnt;
            SEL_DN:    bus_rdata = dn_cnt;
            SEL_MATCH: bus_rdata = r_q.match[midx];
            SEL_CTL:   bus_rdata = DW'(r_q.ctl);
            SEL_ST:    bus_rdata = DW'(status);
            SEL_KEY:   bus_rdata = key_q;
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctl   <= '0;
            r_q.match <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk or negedge pwr_rst_n) begin
        if (!pwr_rst_n) key_q <= '0;
        else            key_q <= key_d;
    end

    assign ctl_en    = r_q.ctl[NUM_MATCH-1:0];
    assign ctl_halt  = r_q.ctl[CTL_HALT];
    assign ctl_swrst = r_q.ctl[CTL_SWRST];
    assign match_val = r_q.match;

    p_key_hold_r10: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        !rst_n |=> $stable(key_q));

    p_stray_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (sel == SEL_NONE)) |=> $stable(r_q) && $stable(key_q));

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_rst_n,
    input  logic          tick_i,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);

    logic [NUM_MATCH-1:0]         ctl_en;
    logic                         ctl_halt;
    logic                         ctl_swrst;
    logic [NUM_MATCH-1:0][DW-1:0] match_val;
    logic                         ld_up;
    logic                         ld_dn;
    logic [NUM_MATCH-1:0]         clr_mask;
    logic [NUM_MATCH-1:0]         status;
    logic [DW-1:0]                up_q;
    logic [DW-1:0]                dn_q;
    logic [DW-1:0]                up_nx;

    sec_rtc_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_rst_n (pwr_rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .up_cnt    (up_q),
        .dn_cnt    (dn_q),
        .status    (status),
        .bus_rdata (bus_rdata),
        .ctl_en    (ctl_en),
        .ctl_halt  (ctl_halt),
        .ctl_swrst (ctl_swrst),
        .match_val (match_val),
        .ld_up     (ld_up),
        .ld_dn     (ld_dn),
        .clr_mask  (clr_mask)
    );

    sec_rtc_count #(.DW(DW)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_i),
        .halt   (ctl_halt),
        .swrst  (ctl_swrst),
        .ld_up  (ld_up),
        .ld_dn  (ld_dn),
        .ld_val (bus_wdata),
        .up_q   (up_q),
        .dn_q   (dn_q),
        .up_nx  (up_nx)
    );

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_match
        sec_rtc_match #(.DW(DW)) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_i),
            .up_nx     (up_nx),
            .match_val (match_val[g]),
            .clr       (clr_mask[g]),
            .st_q      (status[g])
        );
    end

    assign irq_o = |(status & ctl_en);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en == '0) |-> !irq_o);

    p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq_o);

endmodule

// File: tb/sec_rtc_test.sv
module sec_rtc_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    sec_rtc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_rst_n (pwr_rst_n),
        .tick_i    (tick_i),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write and/or tick, applied across exactly one rising edge
    task automatic drive(input logic we, input logic [7:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        tick_i    = tk;
        @(negedge clk);
        bus_we    = 1'b0;
        tick_i    = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 1'b0);
    endtask

    task automatic tk();
        drive(1'b0, 8'h00, 32'h0, 1'b1);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, u;
        repeat (3) @(negedge clk);
        pwr_rst_n = 1'b1;
        rst_n     = 1'b1;
        @(negedge clk);

        // R1 reset state
        rchk("R1 up", 8'h00, 32'h0);
        rchk("R1 down", 8'h04, 32'hFFFFFFFF);
        rchk("R1 match0", 8'h08, 32'hFFFFFFFF);
        rchk("R1 match1", 8'h0C, 32'hFFFFFFFF);
        rchk("R1 ctl", 8'h10, 32'h0);
        rchk("R1 status", 8'h14, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);

        // R2 counting, idle clocks do not count
        for (int i = 1; i <= 5; i++) begin
            tk();
            repeat (2) @(negedge clk);
            rchk("R2 up step", 8'h00, 32'(i));
            rchk("R2 down step", 8'h04, 32'hFFFFFFFF - 32'(i));
        end

        // R3 halt
        wr(8'h10, 32'h40);
        repeat (3) tk();
        rchk("R3 up held", 8'h00, 32'd5);
        rchk("R3 down held", 8'h04, 32'hFFFFFFFA);

        // R4 load while halted, ignored while running
        wr(8'h00, 32'd100);
        wr(8'h04, 32'hFFFFFFFF - 32'd100);
        rchk("R4 up load", 8'h00, 32'd100);
        rchk("R4 down load", 8'h04, 32'hFFFFFF9B);
        wr(8'h10, 32'h0);
        wr(8'h00, 32'd7);
        wr(8'h04, 32'd7);
        rchk("R4 up write ignored", 8'h00, 32'd100);
        rchk("R4 down write ignored", 8'h04, 32'hFFFFFF9B);

        // R6/R9 sweep of match offsets for both match registers
        for (int idx = 0; idx < 2; idx++) begin
            for (int m = 0; m < 12; m++) begin
                logic [31:0] base;
                logic        en;
                base = 32'h1000 + 32'(idx * 64);
                en   = m[0];
                wr(8'h10, 32'h40);
                wr(8'h00, base);
                wr(8'h04, 32'hFFFFFFFF - base);
                wr(8'h08, 32'hFFFFFFFF);
                wr(8'h0C, 32'hFFFFFFFF);
                wr(8'h08 + 8'(idx * 4), base + 32'(m));
                wr(8'h14, 32'h3);
                wr(8'h10, en ? (32'h1 << idx) : 32'h0);
                for (int t = 1; t <= 14; t++) begin
                    logic exp_st;
                    tk();
                    exp_st = (m >= 1) && (t >= m);
                    rd(8'h14, v);
                    chk("R6 status sweep", v, exp_st ? (32'h1 << idx) : 32'h0);
                    chk("R9 irq sweep", {31'h0, irq_o}, {31'h0, exp_st && en});
                end
                rd(8'h00, u);
                rd(8'h04, v);
                chk("R2 sum after sweep", u + v, 32'hFFFFFFFF);
                chk("R2 up after sweep", u, base + 32'd14);
            end
        end

        // R8 re-latch while halted on the match value, R7 clear and set-wins
        wr(8'h10, 32'h40);
        wr(8'h00, 32'h2000);
        wr(8'h08, 32'h2000);
        wr(8'h14, 32'h3);
        rchk("R6 load does not set", 8'h14, 32'h0);
        tk();
        rchk("R8 halted tick sets", 8'h14, 32'h1);
        wr(8'h14, 32'h2);
        rchk("R7 write 0 keeps", 8'h14, 32'h1);
        wr(8'h14, 32'h1);
        rchk("R7 write 1 clears", 8'h14, 32'h0);
        tk();
        rchk("R8 relatch", 8'h14, 32'h1);
        drive(1'b1, 8'h14, 32'h1, 1'b1);
        rchk("R7 set wins over clear", 8'h14, 32'h1);
        wr(8'h08, 32'hFFFFFFFF);
        wr(8'h14, 32'h1);
        tk();
        rchk("R8 moved match stops", 8'h14, 32'h0);

        // R9 gating over all enable combinations with status bit0 only set
        wr(8'h08, 32'h2000);
        tk();
        wr(8'h08, 32'hFFFFFFFF);
        for (int e = 0; e < 4; e++) begin
            wr(8'h10, 32'h40 | 32'(e));
            chk("R9 irq gate", {31'h0, irq_o}, {31'h0, e[0]});
        end

        // R11 control mask, status bit2, unmapped offsets
        wr(8'h14, 32'h7);
        rchk("R11 status bit2 zero", 8'h14, 32'h0);
        wr(8'h10, 32'hFF);
        rchk("R11 ctl mask", 8'h10, 32'hDF);
        wr(8'h18, 32'h12345678);
        wr(8'h1C, 32'hFFFFFFFF);
        wr(8'h80, 32'hFFFFFFFF);
        rchk("R11 unmapped 1C", 8'h1C, 32'h0);
        rchk("R11 unmapped 80", 8'h80, 32'h0);
        rchk("R11 unmapped FC", 8'hFC, 32'h0);
        rchk("R11 ctl untouched", 8'h10, 32'hDF);
        rchk("R11 key untouched", 8'h18, 32'h12345678);
        rchk("R11 match0 untouched", 8'h08, 32'hFFFFFFFF);

        // R5 clear bit: forced, held, ignores loads and ticks
        wr(8'h10, 32'h50);
        rchk("R5 up cleared", 8'h00, 32'h0);
        rchk("R5 down set", 8'h04, 32'hFFFFFFFF);
        wr(8'h00, 32'd33);
        tk();
        rchk("R5 up held", 8'h00, 32'h0);
        wr(8'h10, 32'h0);
        tk();
        rchk("R5 counts after release", 8'h00, 32'h1);

        // R10 key across core reset, cleared by power reset
        wr(8'h18, 32'hB5C13F27);
        rchk("R10 key write", 8'h18, 32'hB5C13F27);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        rchk("R10 key kept", 8'h18, 32'hB5C13F27);
        rchk("R1 up after core reset", 8'h00, 32'h0);
        @(negedge clk); rst_n = 1'b0; pwr_rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; pwr_rst_n = 1'b1;
        @(negedge clk);
        rchk("R10 key cleared", 8'h18, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule